// File: doc/BRIEF.md
# Cipher Accelerator Control and Status Register

This block is the 16-bit control and status word of a block-cipher accelerator. Software uses it to choose the key size, the operation, whether chained block modes with DMA are active, and which chaining mode to use. The block also shows two status flags: one for a finished result and one for a misuse error. Software can write a bit that resets the cipher engine immediately. The block turns that bit into a one-cycle pulse toward the engine, and the bit never reads back as 1.

The two status flags also respond to traffic on neighbouring registers. The bus reports writes to the key and input-data registers, and reads of the output-data register, as one-cycle strobes. The engine reports busy, a done strobe and its remaining block count.

While chained DMA mode is on and blocks remain, the whole word is locked against bus writes. This stops a running transfer from being reconfigured halfway through.

Top module: `cctl_reg`

## Requirements
- R1: After reset the read value is 0x0000, and `irq`, `eng_srst`, `cfg_dma_en`, `cfg_cmode`, `cfg_klen` and `cfg_op` are all 0.
- R2: The read word holds these fields:
  - bit 15: chain enable
  - bit 12: ready interrupt enable
  - bit 11: error flag
  - bit 8: ready flag
  - bits 6:5: chaining mode
  - bits 3:2: key length
  - bits 1:0: operation
  
  Bits 14:13, 10:9, 7 and 4 always read 0. Writes to bits 14:13, 10:9 and 4 are discarded. Writing 0xFF7F therefore reads back as 0x996F.
- R3: While chain enable is 1 and `eng_blk_left` is nonzero, a bus write changes nothing, including the soft-reset bit. When chain enable is 0, writes are accepted whatever the block count.
- R4: `cfg_cmode` carries the stored chaining mode (00 ECB, 01 CBC, 10 OFB, 11 CFB) only while chain enable is 1. Otherwise it drives 00, while the stored value still reads back.
- R5: `cfg_klen` mirrors bits 3:2 (00 = 128-bit key, 01 = 192, 10 = 256, 11 reserved) and `cfg_op` mirrors bits 1:0, both from the cycle after the write.
- R6: An accepted write with bit 7 set clears chain enable, the chaining mode and both flags. It keeps the interrupt enable, key length and operation at their values from before the write. Bit 7 reads 0.
- R7: `eng_srst` is high for exactly the one cycle after an accepted write with bit 7 set.
- R8: The error flag sets when `key_wr` or `din_wr` pulses while `eng_busy` is high. It does not set on such a strobe while the engine is idle. Once set it holds until software writes 0 to bit 11.
- R9: The ready flag sets on `eng_done`. It clears on `dout_rd`, `key_wr` or `din_wr`.
- R10: When a set event and a clearing event reach a flag in the same cycle, the flag ends up set. Clearing events are a strobe or a software write of 0.
- R11: A software write of 1 to bit 8 or bit 11 sets that flag. A write of 0 clears it.
- R12: `irq` equals ready flag AND interrupt enable, in the same cycle the flag becomes readable.
- R13: `cfg_dma_en` is high exactly while chain enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for this register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register value |
| key_wr | input | 1 | Key register was written |
| din_wr | input | 1 | Input-data register was written |
| dout_rd | input | 1 | Output-data register was read |
| eng_busy | input | 1 | Engine operation in progress |
| eng_done | input | 1 | Engine finished an operation (one cycle) |
| eng_blk_left | input | BLK_W | Blocks remaining in the chained transfer |
| irq | output | 1 | Ready interrupt request |
| eng_srst | output | 1 | One-cycle engine reset pulse |
| cfg_dma_en | output | 1 | DMA trigger enable toward the engine |
| cfg_cmode | output | 2 | Effective chaining mode |
| cfg_klen | output | 2 | Key length |
| cfg_op | output | 2 | Operation select |

## Verification
Every state change is registered once. A write or strobe that is present at clock edge k shows up on `bus_rdata`, `irq` and the `cfg_*` outputs right after edge k. The `eng_srst` pulse covers exactly the interval between edges k and k+1. The bench drives each stimulus for one cycle from a falling edge and samples on the next falling edge, so each result is read half a period after the edge that produced it. A second sample, one cycle later, checks the pulse end and the holding of flags.

// File: rtl/cctl_pkg.sv
package cctl_pkg;
    localparam int NFLAG   = 2;
    localparam int FLG_RDY = 0;
    localparam int FLG_ERR = 1;

    localparam int B_CHAIN = 15;
    localparam int B_IE    = 12;
    localparam int B_ERR   = 11;
    localparam int B_RDY   = 8;
    localparam int B_SRST  = 7;
    localparam int B_CM_LO = 5;
    localparam int B_KL_LO = 2;
    localparam int B_OP_LO = 0;

    typedef enum logic [1:0] {
        CM_ECB = 2'b00,
        CM_CBC = 2'b01,
        CM_OFB = 2'b10,
        CM_CFB = 2'b11
    } cmode_e;

    typedef struct packed {
        logic             chain_en;
        logic             rdy_ie;
        cmode_e           cmode;
        logic [1:0]       klen;
        logic [1:0]       op;
        logic [NFLAG-1:0] flag;
        logic             srst_pulse;
        logic             irq;
    } cctl_state_t;
endpackage

// File: rtl/cctl_lock.sv
module cctl_lock #(
    parameter int BLK_W = 8
) (
    input  logic             chain_en,
    input  logic [BLK_W-1:0] blk_left,
    input  logic             bus_wr,
    output logic             locked,
    output logic             wr_ok
);
    // Writes are refused while a chained transfer still has blocks pending.
    always_comb begin
        locked = chain_en && (blk_left != '0);
        wr_ok  = bus_wr && !locked;
    end
endmodule

// File: rtl/cctl_flag.sv
module cctl_flag (
    input  logic cur,
    input  logic wipe,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic sw_wr,
    input  logic sw_val,
    output logic nxt
);
    // Priority: soft reset, then any set source, then any clear source.
    always_comb begin
        if (wipe)
            nxt = 1'b0;
        else if (set_evt || (sw_wr && sw_val))
            nxt = 1'b1;
        else if (clr_evt || sw_wr)
            nxt = 1'b0;
        else
            nxt = cur;
    end
endmodule

// File: rtl/cctl_reg.sv
module cctl_reg
    import cctl_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             key_wr,
    input  logic             din_wr,
    input  logic             dout_rd,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic [BLK_W-1:0] eng_blk_left,
    output logic             irq,
    output logic             eng_srst,
    output logic             cfg_dma_en,
    output logic [1:0]       cfg_cmode,
    output logic [1:0]       cfg_klen,
    output logic [1:0]       cfg_op
);
    cctl_state_t st_q, st_d;
    logic locked, wr_ok, sw_srst;
    logic [NFLAG-1:0] f_set, f_clr, f_sw, f_nxt;

    cctl_lock #(.BLK_W(BLK_W)) u_lock (
        .chain_en (st_q.chain_en),
        .blk_left (eng_blk_left),
        .bus_wr   (bus_wr),
        .locked   (locked),
        .wr_ok    (wr_ok)
    );

    assign sw_srst = wr_ok && bus_wdata[B_SRST];

    always_comb begin
        f_set[FLG_RDY] = eng_done;
        f_clr[FLG_RDY] = dout_rd || key_wr || din_wr;
        f_sw [FLG_RDY] = bus_wdata[B_RDY];
        f_set[FLG_ERR] = (key_wr || din_wr) && eng_busy;
        f_clr[FLG_ERR] = 1'b0;
        f_sw [FLG_ERR] = bus_wdata[B_ERR];
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        cctl_flag u_flag (
            .cur     (st_q.flag[g]),
            .wipe    (sw_srst),
            .set_evt (f_set[g]),
            .clr_evt (f_clr[g]),
            .sw_wr   (wr_ok),
            .sw_val  (f_sw[g]),
            .nxt     (f_nxt[g])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.srst_pulse = sw_srst;
        if (wr_ok) begin
            st_d.chain_en = bus_wdata[B_CHAIN];
            st_d.rdy_ie   = bus_wdata[B_IE];
            st_d.cmode    = cmode_e'(bus_wdata[B_CM_LO +: 2]);
            st_d.klen     = bus_wdata[B_KL_LO +: 2];
            st_d.op       = bus_wdata[B_OP_LO +: 2];
        end
        if (sw_srst) begin
            st_d.chain_en = 1'b0;
            st_d.cmode    = CM_ECB;
            st_d.rdy_ie   = st_q.rdy_ie;
            st_d.klen     = st_q.klen;
            st_d.op       = st_q.op;
        end
        st_d.flag = f_nxt;
        st_d.irq  = f_nxt[FLG_RDY] && st_d.rdy_ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        bus_rdata              = '0;
        bus_rdata[B_CHAIN]     = st_q.chain_en;
        bus_rdata[B_IE]        = st_q.rdy_ie;
        bus_rdata[B_ERR]       = st_q.flag[FLG_ERR];
        bus_rdata[B_RDY]       = st_q.flag[FLG_RDY];
        bus_rdata[B_CM_LO +: 2] = st_q.cmode;
        bus_rdata[B_KL_LO +: 2] = st_q.klen;
        bus_rdata[B_OP_LO +: 2] = st_q.op;
    end

    assign irq        = st_q.irq;
    assign eng_srst   = st_q.srst_pulse;
    assign cfg_dma_en = st_q.chain_en;
    assign cfg_cmode  = st_q.chain_en ? st_q.cmode : CM_ECB;
    assign cfg_klen   = st_q.klen;
    assign cfg_op     = st_q.op;
endmodule

// File: rtl/cctl_reg_chk.sv
module cctl_reg_chk #(
    parameter int BLK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata,
    input logic             key_wr,
    input logic             eng_busy,
    input logic             eng_done,
    input logic [BLK_W-1:0] eng_blk_left,
    input logic             irq,
    input logic             eng_srst,
    input logic             cfg_dma_en
);
    localparam logic [15:0] CFG_MASK = 16'h906F;
    localparam logic [15:0] RSV_MASK = 16'h6690;

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSV_MASK) == 16'h0);

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rdata[15] && eng_blk_left != '0)
        |=> ((bus_rdata & CFG_MASK) == ($past(bus_rdata) & CFG_MASK)) && !eng_srst);

    // R7
    srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_srst |=> !eng_srst);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && eng_busy && !bus_wr) |=> bus_rdata[11]);

    // R9
    rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !bus_wr) |=> bus_rdata[8]);

    // R12
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (bus_rdata[12] && bus_rdata[8]));

    // R13
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dma_en == bus_rdata[15]);

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;
endmodule

bind cctl_reg cctl_reg_chk #(.BLK_W(BLK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .key_wr       (key_wr),
    .eng_busy     (eng_busy),
    .eng_done     (eng_done),
    .eng_blk_left (eng_blk_left),
    .irq          (irq),
    .eng_srst     (eng_srst),
    .cfg_dma_en   (cfg_dma_en)
);

// File: tb/cctl_reg_test.sv
module cctl_reg_test;
    localparam int BLK_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic key_wr = 1'b0, din_wr = 1'b0, dout_rd = 1'b0;
    logic eng_busy = 1'b0, eng_done = 1'b0;
    logic [BLK_W-1:0] eng_blk_left = '0;
    logic irq, eng_srst, cfg_dma_en;
    logic [1:0] cfg_cmode, cfg_klen, cfg_op;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    cctl_reg #(.BLK_W(BLK_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .key_wr(key_wr), .din_wr(din_wr),
        .dout_rd(dout_rd), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_blk_left(eng_blk_left), .irq(irq), .eng_srst(eng_srst),
        .cfg_dma_en(cfg_dma_en), .cfg_cmode(cfg_cmode),
        .cfg_klen(cfg_klen), .cfg_op(cfg_op)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus driven from a falling edge; returns at the next falling edge.
    task automatic cyc(input logic w, input logic [15:0] d, input logic k,
                       input logic di, input logic o, input logic dn);
        bus_wr = w; bus_wdata = d; key_wr = k; din_wr = di; dout_rd = o; eng_done = dn;
        @(negedge clk);
        bus_wr = 1'b0; key_wr = 1'b0; din_wr = 1'b0; dout_rd = 1'b0; eng_done = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 rdata", bus_rdata, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 srst", {15'b0, eng_srst}, 16'h0);
        chk("R1 cfg", {9'b0, cfg_dma_en, cfg_cmode, cfg_klen, cfg_op}, 16'h0);
    endtask

    task automatic t_layout;
        wr(16'hFF7F);
        chk("R2 readback", bus_rdata, 16'h996F);
        chk("R4 cmode on", {14'b0, cfg_cmode}, 16'h3);
        chk("R5 klen", {14'b0, cfg_klen}, 16'h3);
        chk("R5 op", {14'b0, cfg_op}, 16'h3);
        chk("R13 dma on", {15'b0, cfg_dma_en}, 16'h1);
        chk("R12 irq on", {15'b0, irq}, 16'h1);
        wr(16'h0060);
        chk("R4 stored", bus_rdata, 16'h0060);
        chk("R4 cmode gated", {14'b0, cfg_cmode}, 16'h0);
        chk("R13 dma off", {15'b0, cfg_dma_en}, 16'h0);
        wr(16'h8020);
        chk("R4 cbc", {14'b0, cfg_cmode}, 16'h1);
    endtask

    task automatic t_klen;
        wr(16'h0009);
        chk("R5 klen 256", {14'b0, cfg_klen}, 16'h2);
        chk("R5 op 1", {14'b0, cfg_op}, 16'h1);
        wr(16'h0004);
        chk("R5 klen 192", {14'b0, cfg_klen}, 16'h1);
    endtask

    task automatic t_soft;
        wr(16'h996F);
        wr(16'h0080);
        chk("R7 pulse high", {15'b0, eng_srst}, 16'h1);
        chk("R6 kept fields", bus_rdata, 16'h100F);
        @(negedge clk);
        chk("R7 pulse low", {15'b0, eng_srst}, 16'h0);
        wr(16'h0000);
    endtask

    task automatic t_err;
        eng_busy = 1'b1;
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 set key busy", {15'b0, bus_rdata[11]}, 16'h1);
        eng_busy = 1'b0;
        cyc(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 hold", {15'b0, bus_rdata[11]}, 16'h1);
        wr(16'h0000);
        chk("R8 sw clear", {15'b0, bus_rdata[11]}, 16'h0);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 idle no set", {15'b0, bus_rdata[11]}, 16'h0);
        eng_busy = 1'b1;
        cyc(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 set din busy", {15'b0, bus_rdata[11]}, 16'h1);
        eng_busy = 1'b0;
        wr(16'h0000);
    endtask

    task automatic t_rdy;
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 set", {15'b0, bus_rdata[8]}, 16'h1);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 clr dout", {15'b0, bus_rdata[8]}, 16'h0);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 clr key", {15'b0, bus_rdata[8]}, 16'h0);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 clr din", {15'b0, bus_rdata[8]}, 16'h0);
    endtask

    task automatic t_setwins;
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 done vs dout", {15'b0, bus_rdata[8]}, 16'h1);
        cyc(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 done vs sw0", {15'b0, bus_rdata[8]}, 16'h1);
        wr(16'h0000);
    endtask

    task automatic t_sw;
        wr(16'h0900);
        chk("R11 sw set", bus_rdata, 16'h0900);
        chk("R12 irq masked", {15'b0, irq}, 16'h0);
        wr(16'h1900);
        chk("R12 irq on", {15'b0, irq}, 16'h1);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12 irq off", {15'b0, irq}, 16'h0);
        wr(16'h0000);
        chk("R11 sw clear", bus_rdata, 16'h0000);
    endtask

    task automatic t_lock;
        wr(16'h8000);
        eng_blk_left = 8'd3;
        wr(16'h1005);
        chk("R3 locked data", bus_rdata, 16'h8000);
        wr(16'h0080);
        chk("R3 locked srst", {15'b0, eng_srst}, 16'h0);
        chk("R3 locked keep", bus_rdata, 16'h8000);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 sideband while locked", bus_rdata, 16'h8100);
        eng_blk_left = 8'd0;
        wr(16'h0004);
        chk("R3 unlocked", bus_rdata, 16'h0004);
        eng_blk_left = 8'd5;
        wr(16'h0020);
        chk("R3 no chain accepts", bus_rdata, 16'h0020);
        eng_blk_left = 8'd0;
        wr(16'h0000);
    endtask

    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_klen();
        t_soft();
        t_err();
        t_rdy();
        t_setwins();
        t_sw();
        t_lock();
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule